// File: doc/BRIEF.md
# Register command packet interpreter

The block takes a stream of fixed-length command packets, one byte per valid/ready handshake. It turns each packet into a series of single-cycle accesses on a simple internal register bus. A packet is 26 bytes long. It starts with an opcode byte and a reserved byte. Eight three-byte entries follow, each holding a register address, a data byte and a padding byte. A write packet turns each entry into a register write. A read packet turns each entry into a register read. Once every entry has run, it returns a 24-byte response. In that response each entry owns a three-byte slot that carries the value read and a status code.

Entries run strictly in the order they appear in the packet. An address byte of 0xFE marks the end of the useful entries. The bytes that follow it are still consumed, so that the input stays aligned to packet boundaries, but they cause no access. One register address, 0x0C, fronts a data queue. A read of that address while the queue is empty is flagged in the status byte of its slot. While a response is being sent, the input is held not-ready.

Top module: `regpkt_engine`

## Requirements
- R1: Opcode 0x99 (byte 0) makes each executed entry issue exactly one register write, with regAddr equal to the entry's address byte and regWdata equal to its data byte. The padding byte has no effect.
- R2: Entries execute in packet order, so several writes to the same address land in sequence and the last one wins.
- R3: An address byte of 0xFE stops execution: that entry and every later entry of the packet cause no access. The packet still consumes all 26 bytes.
- R4: Opcode 0xDD makes each executed entry issue exactly one register read. The entry's data byte causes no write. The response is exactly 24 bytes. For entry i, byte 3i is 0x00, byte 3i+1 is the value read and byte 3i+2 is the status.
- R5: The status byte is 0x04 when address 0x0C is read while regFifoEmpty is high. Every other executed read gets status 0x00.
- R6: In the response, the slot of an entry that did not execute (terminated or absent) is all zeros.
- R7: A packet whose opcode is neither 0x99 nor 0xDD is consumed in full (26 bytes) and produces no register access and no response. The next packet is parsed normally.
- R8: The response starts only after the last entry's access has completed. inReady stays low while the response is being sent. outData and outValid hold while outReady is low.
- R9: regWe and regRe are never high in the same cycle.
- R10: After reset, inReady is high, outValid is low, and regWe and regRe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Command byte valid |
| inData | input | 8 | Command byte |
| inReady | output | 1 | Block accepts a command byte |
| outValid | output | 1 | Response byte valid |
| outData | output | 8 | Response byte |
| outReady | input | 1 | Consumer accepts a response byte |
| regAddr | output | 8 | Register bus address |
| regWdata | output | 8 | Register bus write data |
| regWe | output | 1 | Single-cycle write strobe |
| regRe | output | 1 | Single-cycle read strobe; regRdata is sampled in the same cycle |
| regRdata | input | 8 | Register bus read data |
| regFifoEmpty | input | 1 | Data queue behind address 0x0C is empty |

## Verification
The embedded properties check, on every cycle, the following:
- Write and read strobes never coincide.
- No access follows a terminator.
- No access is made under an unrecognised opcode.
- Response slots are cleared when a packet starts.
- Status bytes take only their two legal codes.
- The response stays stable under backpressure.
- The response starts only after the drain cycle.

What only the directed scenarios can show is end to end:
- the order and values of the writes on the bus;
- that an unknown packet is really 26 bytes long, because the next packet still lands;
- the exact byte placement of values and status codes in a response, including the empty-queue case;
- the all-zero slots after an early terminator.

// File: rtl/regpkt_pkg.sv
`timescale 1ns/1ps
package regpkt_pkg;
  localparam int BYTE_W    = 8;
  localparam int ENTRY_CNT = 8;
  localparam int HDR_LEN   = 2;
  localparam int ENTRY_LEN = 3;
  localparam int PKT_LEN   = HDR_LEN + ENTRY_CNT * ENTRY_LEN;
  localparam int RSP_LEN   = ENTRY_CNT * ENTRY_LEN;
  localparam int SLOT_W    = $clog2(ENTRY_CNT);
  localparam int CNT_W     = $clog2(PKT_LEN);

  localparam logic [BYTE_W-1:0] OPC_WRITE  = 8'h99;
  localparam logic [BYTE_W-1:0] OPC_READ   = 8'hDD;
  localparam logic [BYTE_W-1:0] ADDR_END   = 8'hFE;
  localparam logic [BYTE_W-1:0] ADDR_DATAQ = 8'h0C;
  localparam logic [BYTE_W-1:0] STAT_OK    = 8'h00;
  localparam logic [BYTE_W-1:0] STAT_EMPTY = 8'h04;

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD} opKind_t;
  typedef enum logic [1:0] {ST_RECV, ST_DRAIN, ST_SEND} ctrlState_t;

  // strobes and indices from control to datapath
  typedef struct packed {
    logic              clrBuf;
    logic              capAddr;
    logic              capData;
    logic              issueWr;
    logic              issueRd;
    logic [SLOT_W-1:0] issueSlot;
    logic [SLOT_W-1:0] sendSlot;
    logic [1:0]        sendPhase;
  } dpCmd_t;

  function automatic opKind_t decodeOp(input logic [BYTE_W-1:0] b);
    if (b == OPC_WRITE)     return OP_WR;
    else if (b == OPC_READ) return OP_RD;
    else                    return OP_NONE;
  endfunction
endpackage

// File: rtl/regpkt_ctrl.sv
`timescale 1ns/1ps
module regpkt_ctrl
  import regpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output dpCmd_t            cmd
);
  ctrlState_t        state;
  logic [CNT_W-1:0]  byteCnt;
  logic [1:0]        entPhase;
  logic [SLOT_W-1:0] entIdx;
  opKind_t           opKind;
  logic              termSeen;
  logic              issueWr, issueRd;
  logic [SLOT_W-1:0] issueSlot;
  logic [SLOT_W-1:0] sendSlot;
  logic [1:0]        sendPhase;

  logic inFire, outFire, inBody;

  assign inReady  = (state == ST_RECV);
  assign outValid = (state == ST_SEND);
  assign inFire   = inValid && inReady;
  assign outFire  = outValid && outReady;
  assign inBody   = (byteCnt >= CNT_W'(HDR_LEN));

  always_comb begin
    cmd           = '0;
    cmd.clrBuf    = inFire && (byteCnt == '0);
    cmd.capAddr   = inFire && inBody && (entPhase == 2'd0);
    cmd.capData   = inFire && inBody && (entPhase == 2'd1);
    cmd.issueWr   = issueWr;
    cmd.issueRd   = issueRd;
    cmd.issueSlot = issueSlot;
    cmd.sendSlot  = sendSlot;
    cmd.sendPhase = sendPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RECV;
      byteCnt   <= '0;
      entPhase  <= '0;
      entIdx    <= '0;
      opKind    <= OP_NONE;
      termSeen  <= 1'b0;
      issueWr   <= 1'b0;
      issueRd   <= 1'b0;
      issueSlot <= '0;
      sendSlot  <= '0;
      sendPhase <= '0;
    end else begin
      issueWr <= 1'b0;
      issueRd <= 1'b0;
      unique case (state)
        ST_RECV: if (inFire) begin
          if (byteCnt == CNT_W'(PKT_LEN - 1)) begin
            byteCnt <= '0;
            state   <= ST_DRAIN;
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
          if (byteCnt == '0) begin
            opKind   <= decodeOp(inData);
            termSeen <= 1'b0;
            entPhase <= '0;
            entIdx   <= '0;
          end else if (inBody) begin
            unique case (entPhase)
              2'd0: begin
                if (inData == ADDR_END) termSeen <= 1'b1;
                entPhase <= 2'd1;
              end
              2'd1: entPhase <= 2'd2;
              default: begin
                entPhase <= 2'd0;
                entIdx   <= entIdx + 1'b1;
                if (!termSeen) begin
                  issueWr   <= (opKind == OP_WR);
                  issueRd   <= (opKind == OP_RD);
                  issueSlot <= entIdx;
                end
              end
            endcase
          end
        end
        ST_DRAIN: begin
          sendSlot  <= '0;
          sendPhase <= '0;
          state     <= (opKind == OP_RD) ? ST_SEND : ST_RECV;
        end
        default: if (outFire) begin
          if (sendPhase == 2'(ENTRY_LEN - 1)) begin
            sendPhase <= '0;
            if (sendSlot == SLOT_W'(ENTRY_CNT - 1)) state <= ST_RECV;
            else sendSlot <= sendSlot + 1'b1;
          end else begin
            sendPhase <= sendPhase + 1'b1;
          end
        end
      endcase
    end
  end

  // R3: no access once a terminator was seen in this packet
  a_r3_no_access_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (issueWr || issueRd) |-> !termSeen);
  // R7: unrecognised opcode never produces an access
  a_r7_no_access_bad_op: assert property (@(posedge clk) disable iff (!rstN)
    (issueWr || issueRd) |-> (opKind != OP_NONE));
  // R1: writes only under a write opcode
  a_r1_write_needs_wr_op: assert property (@(posedge clk) disable iff (!rstN)
    issueWr |-> (opKind == OP_WR));
  // R8: response stalls cleanly under backpressure
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(sendSlot) && $stable(sendPhase)));
  // R8: response begins only after the drain cycle carrying the last access
  a_r8_send_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> ($past(state) == ST_DRAIN));
  // R8: input blocked whenever a response byte is offered
  a_r8_in_blocked: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
endmodule

// File: rtl/regpkt_dp.sv
`timescale 1ns/1ps
module regpkt_dp
  import regpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [BYTE_W-1:0] regRdata,
  input  logic              regFifoEmpty,
  output logic [BYTE_W-1:0] outData
);
  logic [BYTE_W-1:0] addrReg, dataReg;
  logic [BYTE_W-1:0] rdStatus;
  logic [BYTE_W-1:0] slotValArr [ENTRY_CNT];
  logic [BYTE_W-1:0] slotStArr  [ENTRY_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (cmd.capAddr) addrReg <= inData;
      if (cmd.capData) dataReg <= inData;
    end
  end

  assign regAddr  = addrReg;
  assign regWdata = dataReg;
  assign regWe    = cmd.issueWr;
  assign regRe    = cmd.issueRd;
  assign rdStatus = ((addrReg == ADDR_DATAQ) && regFifoEmpty) ? STAT_EMPTY : STAT_OK;

  for (genvar g = 0; g < ENTRY_CNT; g++) begin : g_slot
    logic [BYTE_W-1:0] val, st;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val <= '0;
        st  <= '0;
      end else if (cmd.clrBuf) begin
        val <= '0;
        st  <= '0;
      end else if (cmd.issueRd && (cmd.issueSlot == SLOT_W'(g))) begin
        val <= regRdata;
        st  <= rdStatus;
      end
    end
    assign slotValArr[g] = val;
    assign slotStArr[g]  = st;

    // R6: a new packet starts from an all-zero slot
    a_r6_slot_cleared: assert property (@(posedge clk) disable iff (!rstN)
      cmd.clrBuf |=> (val == '0 && st == '0));
    // R5: status takes only its two legal codes
    a_r5_status_legal: assert property (@(posedge clk) disable iff (!rstN)
      (st == STAT_OK) || (st == STAT_EMPTY));
  end

  always_comb begin
    unique case (cmd.sendPhase)
      2'd1:    outData = slotValArr[cmd.sendSlot];
      2'd2:    outData = slotStArr[cmd.sendSlot];
      default: outData = '0;
    endcase
  end

  // R9: one kind of access per cycle
  a_r9_single_access: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));
endmodule

// File: rtl/regpkt_engine.sv
`timescale 1ns/1ps
module regpkt_engine
  import regpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  input  logic              outReady,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [BYTE_W-1:0] regRdata,
  input  logic              regFifoEmpty
);
  dpCmd_t cmd;

  regpkt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .cmd(cmd)
  );

  regpkt_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inData(inData),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata), .regFifoEmpty(regFifoEmpty), .outData(outData)
  );
endmodule

// File: tb/regpkt_engine_bench.sv
`timescale 1ns/1ps
module regpkt_engine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady;
  logic outValid;
  logic [7:0] outData;
  logic outReady = 1'b0;
  logic [7:0] regAddr, regWdata, regRdata;
  logic regWe, regRe, regFifoEmpty;

  always #5 clk = ~clk;

  regpkt_engine u_regpkt_engine (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata), .regFifoEmpty(regFifoEmpty)
  );

  // register file model with an 8-deep queue at address 0x0C
  logic [7:0] regs [256];
  logic [7:0] fifoMem [8];
  logic [2:0] fifoWr = '0, fifoRd = '0;
  logic [3:0] fifoCnt = '0;
  logic [7:0] wrLogA [64];
  logic [7:0] wrLogD [64];
  int wrCnt = 0, rdCnt = 0, bothCnt = 0, ovCnt = 0;

  initial for (int i = 0; i < 256; i++) regs[i] = 8'h00;

  always_comb begin
    regFifoEmpty = (fifoCnt == 4'd0);
    if (regAddr == 8'h0C) regRdata = regFifoEmpty ? 8'h00 : fifoMem[fifoRd];
    else                  regRdata = regs[regAddr];
  end

  always @(posedge clk) begin
    if (regWe && regRe) bothCnt <= bothCnt + 1;
    if (outValid) ovCnt <= ovCnt + 1;
    if (regWe) begin
      if (wrCnt < 64) begin
        wrLogA[wrCnt] <= regAddr;
        wrLogD[wrCnt] <= regWdata;
      end
      wrCnt <= wrCnt + 1;
      if (regAddr == 8'h0C) begin
        if (fifoCnt < 4'd8) begin
          fifoMem[fifoWr] <= regWdata;
          fifoWr <= fifoWr + 1'b1;
          fifoCnt <= fifoCnt + 1'b1;
        end
      end else begin
        regs[regAddr] <= regWdata;
      end
    end
    if (regRe) begin
      rdCnt <= rdCnt + 1;
      if (regAddr == 8'h0C && fifoCnt != 4'd0) begin
        fifoRd <= fifoRd + 1'b1;
        fifoCnt <= fifoCnt - 1'b1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] pkt [26];
  logic [7:0] rsp [24];
  logic [7:0] expRsp [24];
  int busyIn = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic initPkt(input logic [7:0] op);
    for (int i = 0; i < 26; i++) pkt[i] = 8'hFE;
    pkt[0] = op;
    pkt[1] = 8'h00;
  endtask

  task automatic setEntry(input int i, input logic [7:0] a, input logic [7:0] d, input logic [7:0] pad);
    pkt[2 + 3*i] = a;
    pkt[3 + 3*i] = d;
    pkt[4 + 3*i] = pad;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic sendPkt();
    for (int i = 0; i < 26; i++) pushByte(pkt[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic getResponse(input bit stall);
    int k = 0;
    busyIn = 0;
    while (k < 24) begin
      @(negedge clk);
      outReady = stall ? ~outReady : 1'b1;
      if (outValid && outReady) begin
        rsp[k] = outData;
        if (inReady) busyIn++;
        k++;
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    chk("R4 response ends after 24 bytes", outValid, 1'b0);
    chk("R8 input held while response sent", busyIn, 0);
  endtask

  task automatic compareRsp(input string tag);
    for (int i = 0; i < 24; i++)
      chk($sformatf("%s byte %0d", tag, i), rsp[i], expRsp[i]);
  endtask

  task automatic testReset();
    chk("R10 inReady after reset", inReady, 1'b1);
    chk("R10 outValid after reset", outValid, 1'b0);
    chk("R10 no write strobe", regWe, 1'b0);
    chk("R10 no read strobe", regRe, 1'b0);
  endtask

  task automatic testWriteOrder();
    int base = wrCnt;
    initPkt(8'h99);
    setEntry(0, 8'h30, 8'h80, 8'h00);
    setEntry(1, 8'h30, 8'h81, 8'h00);
    setEntry(2, 8'h14, 8'hFF, 8'hEE);
    sendPkt();
    chk("R1 three writes", wrCnt - base, 3);
    chk("R2 first write addr", wrLogA[base], 8'h30);
    chk("R2 first write data", wrLogD[base], 8'h80);
    chk("R2 second write data", wrLogD[base+1], 8'h81);
    chk("R1 third write addr", wrLogA[base+2], 8'h14);
    chk("R1 third write data despite pad", wrLogD[base+2], 8'hFF);
    chk("R2 last write wins", regs[8'h30], 8'h81);
    chk("R1 no response for write", outValid, 1'b0);
  endtask

  task automatic testTerminate();
    int base = wrCnt;
    initPkt(8'h99);
    setEntry(0, 8'h20, 8'h11, 8'h00);
    setEntry(2, 8'h21, 8'h22, 8'h00);
    sendPkt();
    chk("R3 only entry before terminator runs", wrCnt - base, 1);
    chk("R3 entry before terminator written", regs[8'h20], 8'h11);
    chk("R3 entry after terminator skipped", regs[8'h21], 8'h00);
  endtask

  task automatic testReadQueue();
    int wb, rb;
    initPkt(8'h99);
    setEntry(0, 8'h0C, 8'hA1, 8'h00);
    setEntry(1, 8'h0C, 8'hA2, 8'h00);
    setEntry(2, 8'h0C, 8'hA3, 8'h00);
    sendPkt();
    wb = wrCnt;
    rb = rdCnt;
    initPkt(8'hDD);
    for (int i = 0; i < 4; i++) setEntry(i, 8'h0C, 8'h5A, 8'h00);
    setEntry(4, 8'h30, 8'h5A, 8'h00);
    sendPkt();
    chk("R8 response waits for consumer", outValid, 1'b1);
    chk("R8 input blocked before response", inReady, 1'b0);
    getResponse(1'b1);
    for (int i = 0; i < 24; i++) expRsp[i] = 8'h00;
    expRsp[1] = 8'hA1;
    expRsp[4] = 8'hA2;
    expRsp[7] = 8'hA3;
    expRsp[10] = 8'h00; expRsp[11] = 8'h04;
    expRsp[13] = 8'h81;
    compareRsp("R4 R5 R6 read response");
    chk("R4 five reads issued", rdCnt - rb, 5);
    chk("R4 data byte of reads causes no write", wrCnt - wb, 0);
    chk("R5 empty status code", rsp[11], 8'h04);
    chk("R6 terminated slot zero", rsp[17], 8'h00);
  endtask

  task automatic testUnknownOp();
    int wb = wrCnt, rb = rdCnt, ob = ovCnt;
    initPkt(8'h42);
    setEntry(0, 8'h31, 8'h77, 8'h00);
    setEntry(1, 8'hDD, 8'h99, 8'h00);
    sendPkt();
    chk("R7 no write for unknown opcode", wrCnt - wb, 0);
    chk("R7 no read for unknown opcode", rdCnt - rb, 0);
    chk("R7 no response for unknown opcode", ovCnt - ob, 0);
    chk("R7 register untouched", regs[8'h31], 8'h00);
    initPkt(8'h99);
    setEntry(0, 8'h32, 8'h33, 8'h00);
    sendPkt();
    chk("R7 next packet aligned", regs[8'h32], 8'h33);
    chk("R7 next packet single write", wrCnt - wb, 1);
  endtask

  task automatic testFullRead();
    initPkt(8'h99);
    for (int i = 0; i < 8; i++) setEntry(i, 8'h40 + 8'(i), 8'h10 * 8'(i) + 8'h3, 8'h00);
    sendPkt();
    initPkt(8'hDD);
    for (int i = 0; i < 8; i++) setEntry(i, 8'h40 + 8'(i), 8'h00, 8'h00);
    sendPkt();
    getResponse(1'b0);
    for (int i = 0; i < 8; i++) begin
      expRsp[3*i]   = 8'h00;
      expRsp[3*i+1] = 8'h10 * 8'(i) + 8'h3;
      expRsp[3*i+2] = 8'h00;
    end
    compareRsp("R4 full eight-entry response");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteOrder();
    testTerminate();
    testReadQueue();
    testUnknownOp();
    testFullRead();
    chk("R9 no coincident strobes", bothCnt, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule